// File: doc/BRIEF.md
# Bus Acknowledge Timeout Watchdog

This block sits between a processor core's bus master port and the slave side of a Wishbone-style bus. The core's own bus logic gives up after a short fixed number of cycles. To stretch that limit, the block raises a wait request to the core as soon as the core has a strobe outstanding. It keeps the wait request up for as long as the slave has not answered.

If the slave answers within `LIMIT` bus clocks, the acknowledge passes straight to the core and the transfer ends normally. If it does not, the block withdraws the wait request so that the core's own short timeout can complete. At the same moment the block forces strobe and cycle low toward the slave and raises an abort flag. It also emits a one-cycle timeout pulse for status or debug use.

A new window starts at every fresh strobe, and also after every acknowledge while strobe stays high. This gives each transfer in a back-to-back burst its own full window. No data passes through the block, so it has no valid/ready stream interface. Every pin is a plain level or pulse, and there is no back-pressure.

Top module: `wb_ack_watchdog`

## Requirements
- R1: While no abort is in force, `bus_cyc_o` equals `core_cyc_i`, `bus_stb_o` equals `core_stb_i`, and `core_ack_o` equals `bus_ack_i` AND `core_cyc_i` AND `core_stb_i`.
- R2: `core_wait_o` is 1 in every cycle in which `core_cyc_i` and `core_stb_i` are both 1 and no abort is in force, and 0 in every other cycle.
- R3: When `core_cyc_i` and `core_stb_i` are both 1 for `LIMIT` consecutive cycles (default 4096) with `bus_ack_i` 0 in all of them, `abort_o` becomes 1 in the cycle after the last of those cycles. It does not become 1 earlier.
- R4: The window restarts from zero whenever strobe or cycle is low and after every cycle that carries an acknowledge. A transfer that follows an acknowledge back-to-back therefore gets a full `LIMIT` cycles.
- R5: While `abort_o` is 1, `bus_stb_o`, `bus_cyc_o`, `core_wait_o` and `core_ack_o` are all 0, whatever the inputs.
- R6: Once raised, `abort_o` stays 1 while the core keeps both cycle and strobe high. It returns to 0 in the cycle after the core drops either of them.
- R7: `timeout_o` is a single-cycle pulse that is 1 exactly in the first cycle of each abort.
- R8: An acknowledge that arrives in the last cycle of the window (the `LIMIT`-th cycle) completes the transfer, and no abort or timeout pulse follows.
- R9: A synchronous reset (`rst` high at a clock edge) clears the window, the abort state and the timeout pulse, so `abort_o` and `timeout_o` are 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| core_cyc_i | input | 1 | Cycle request from the core |
| core_stb_i | input | 1 | Strobe request from the core |
| core_ack_o | output | 1 | Acknowledge forwarded to the core |
| core_wait_o | output | 1 | Wait request to the core, holds off its internal timeout |
| bus_cyc_o | output | 1 | Cycle toward the slave, forced low during abort |
| bus_stb_o | output | 1 | Strobe toward the slave, forced low during abort |
| bus_ack_i | input | 1 | Acknowledge from the slave |
| abort_o | output | 1 | High while a timed-out transfer is being killed |
| timeout_o | output | 1 | One-cycle pulse in the first cycle of an abort |

## Verification
The window is driven in several ways: with acknowledge delays that are short and random, with an acknowledge in the final cycle, and with no acknowledge at all. These patterns separate an off-by-one window from a correct one, and show whether an acknowledge beats expiry in the same cycle. Strobes that stay high across an acknowledge show whether the window restarts per transfer rather than per strobe rise. Stray acknowledges while idle, cycle without strobe, and a reset in the middle of an abort show whether forwarding is gated on a live request and whether reset clears the kill state.

// File: rtl/wb_tmo_pkg.sv
package wb_tmo_pkg;

  typedef enum logic {
    PH_OPEN   = 1'b0,
    PH_KILLED = 1'b1
  } ph_e;

  function automatic int cnt_width(input int lim);
    return (lim < 2) ? 1 : $clog2(lim);
  endfunction

endpackage

// File: rtl/wb_tmo_gate.sv
module wb_tmo_gate (
  input  logic core_cyc_i,
  input  logic core_stb_i,
  input  logic bus_ack_i,
  input  logic killed,
  output logic live,
  output logic core_ack_o,
  output logic core_wait_o,
  output logic bus_cyc_o,
  output logic bus_stb_o
);

  logic req;

  always_comb begin
    req         = core_cyc_i & core_stb_i;
    live        = req & ~killed;
    bus_cyc_o   = core_cyc_i & ~killed;
    bus_stb_o   = core_stb_i & ~killed;
    core_ack_o  = live & bus_ack_i;
    core_wait_o = live;
  end

endmodule

// File: rtl/wb_tmo_window.sv
module wb_tmo_window #(
  parameter int LIMIT = 4096
) (
  input  logic clk,
  input  logic rst,
  input  logic live,
  input  logic ack,
  output logic expire
);

  localparam int CW = wb_tmo_pkg::cnt_width(LIMIT);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !live || ack) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  always_comb begin
    expire = live & ~ack & (cnt == LAST);
  end

endmodule

// File: rtl/wb_tmo_ctrl.sv
module wb_tmo_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic core_cyc_i,
  input  logic core_stb_i,
  input  logic expire,
  output logic killed,
  output logic timeout_o
);

  import wb_tmo_pkg::*;

  ph_e ph_q;
  ph_e ph_d;

  always_comb begin
    ph_d = ph_q;
    case (ph_q)
      PH_OPEN:   if (expire) ph_d = PH_KILLED;
      PH_KILLED: if (!(core_cyc_i && core_stb_i)) ph_d = PH_OPEN;
      default:   ph_d = PH_OPEN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q      <= PH_OPEN;
      timeout_o <= 1'b0;
    end else begin
      ph_q      <= ph_d;
      timeout_o <= (ph_q == PH_OPEN) && expire;
    end
  end

  assign killed = (ph_q == PH_KILLED);

endmodule

// File: rtl/wb_ack_watchdog.sv
module wb_ack_watchdog #(
  parameter int LIMIT = 4096
) (
  input  logic clk,
  input  logic rst,
  input  logic core_cyc_i,
  input  logic core_stb_i,
  output logic core_ack_o,
  output logic core_wait_o,
  output logic bus_cyc_o,
  output logic bus_stb_o,
  input  logic bus_ack_i,
  output logic abort_o,
  output logic timeout_o
);

  logic live;
  logic killed;
  logic expire;

  wb_tmo_gate u_gate (
    .core_cyc_i (core_cyc_i),
    .core_stb_i (core_stb_i),
    .bus_ack_i  (bus_ack_i),
    .killed     (killed),
    .live       (live),
    .core_ack_o (core_ack_o),
    .core_wait_o(core_wait_o),
    .bus_cyc_o  (bus_cyc_o),
    .bus_stb_o  (bus_stb_o)
  );

  wb_tmo_window #(.LIMIT(LIMIT)) u_window (
    .clk   (clk),
    .rst   (rst),
    .live  (live),
    .ack   (bus_ack_i),
    .expire(expire)
  );

  wb_tmo_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .core_cyc_i(core_cyc_i),
    .core_stb_i(core_stb_i),
    .expire    (expire),
    .killed    (killed),
    .timeout_o (timeout_o)
  );

  assign abort_o = killed;

endmodule

// File: rtl/wb_ack_watchdog_chk.sv
module wb_ack_watchdog_chk #(
  parameter int LIMIT = 4096
) (
  input logic clk,
  input logic rst,
  input logic core_cyc_i,
  input logic core_stb_i,
  input logic core_ack_o,
  input logic core_wait_o,
  input logic bus_cyc_o,
  input logic bus_stb_o,
  input logic bus_ack_i,
  input logic abort_o,
  input logic timeout_o
);

  localparam int SW = $clog2(LIMIT + 1) + 1;

  logic          req;
  logic [SW-1:0] silent;

  assign req = core_cyc_i && core_stb_i;

  always_ff @(posedge clk) begin
    if (rst || !req || bus_ack_i || abort_o) begin
      silent <= '0;
    end else begin
      silent <= silent + 1'b1;
    end
  end

  // R3, R4: abort only after exactly LIMIT silent cycles
  a_r3_abort_at_limit: assert property (@(posedge clk) disable iff (rst)
    $rose(abort_o) |-> (silent == SW'(LIMIT)));

  a_r4_no_overrun: assert property (@(posedge clk) disable iff (rst)
    !abort_o |-> (silent <= SW'(LIMIT)));

  // R5: everything toward slave and core is quiet during abort
  a_r5_kill_outputs: assert property (@(posedge clk) disable iff (rst)
    abort_o |-> (!bus_stb_o && !bus_cyc_o && !core_wait_o && !core_ack_o));

  // R2: a live request is always held off
  a_r2_wait_held: assert property (@(posedge clk) disable iff (rst)
    (req && !abort_o) |-> core_wait_o);

  // R6: abort hold and release
  a_r6_abort_hold: assert property (@(posedge clk) disable iff (rst)
    (abort_o && req) |=> abort_o);

  a_r6_abort_release: assert property (@(posedge clk) disable iff (rst)
    (abort_o && !req) |=> !abort_o);

  // R7: timeout pulse is single and marks abort entry
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
    timeout_o |=> !timeout_o);

  a_r7_pulse_on_entry: assert property (@(posedge clk) disable iff (rst)
    timeout_o |-> (abort_o && !$past(abort_o)));

  // R8: an acknowledge on a live request never leads to a timeout
  a_r8_ack_wins: assert property (@(posedge clk) disable iff (rst)
    (req && bus_ack_i && !abort_o) |=> !timeout_o);

  // R9: reset clears abort and pulse
  a_r9_reset_clears: assert property (@(posedge clk)
    rst |=> (!abort_o && !timeout_o));

endmodule

bind wb_ack_watchdog wb_ack_watchdog_chk #(.LIMIT(LIMIT)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .core_cyc_i (core_cyc_i),
  .core_stb_i (core_stb_i),
  .core_ack_o (core_ack_o),
  .core_wait_o(core_wait_o),
  .bus_cyc_o  (bus_cyc_o),
  .bus_stb_o  (bus_stb_o),
  .bus_ack_i  (bus_ack_i),
  .abort_o    (abort_o),
  .timeout_o  (timeout_o)
);

// File: tb/wb_ack_watchdog_bench.sv
module wb_ack_watchdog_bench;

  localparam int CLK_PERIOD = 10;
  localparam int LIMIT      = 4096;
  localparam int WD_CYCLES  = 190000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic core_cyc_i = 1'b0;
  logic core_stb_i = 1'b0;
  logic bus_ack_i  = 1'b0;
  logic core_ack_o, core_wait_o, bus_cyc_o, bus_stb_o, abort_o, timeout_o;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  // reference state
  int m_cnt    = 0;
  bit m_killed = 1'b0;
  bit m_tmo    = 1'b0;

  // values sampled in the latest step
  logic s_abort, s_tmo, s_wait, s_stb;

  always #(CLK_PERIOD / 2) clk = ~clk;

  wb_ack_watchdog #(.LIMIT(LIMIT)) u_wb_ack_watchdog (
    .clk        (clk),
    .rst        (rst),
    .core_cyc_i (core_cyc_i),
    .core_stb_i (core_stb_i),
    .core_ack_o (core_ack_o),
    .core_wait_o(core_wait_o),
    .bus_cyc_o  (bus_cyc_o),
    .bus_stb_o  (bus_stb_o),
    .bus_ack_i  (bus_ack_i),
    .abort_o    (abort_o),
    .timeout_o  (timeout_o)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit exp_live(input bit c, input bit s);
    return c && s && !m_killed;
  endfunction

  function automatic bit exp_expire(input bit c, input bit s, input bit a);
    return exp_live(c, s) && !a && (m_cnt == LIMIT - 1);
  endfunction

  task automatic step(input bit r, input bit c, input bit s, input bit a);
    string fw;
    bit lv, ex;
    @(negedge clk);
    rst = r; core_cyc_i = c; core_stb_i = s; bus_ack_i = a;
    #1;
    lv = exp_live(c, s);
    fw = m_killed ? "R5" : "R1";
    chk(fw, "bus_stb", bus_stb_o, s && !m_killed);
    chk(fw, "bus_cyc", bus_cyc_o, c && !m_killed);
    chk(fw, "core_ack", core_ack_o, lv && a);
    chk("R2", "core_wait", core_wait_o, lv);
    chk("R3", "abort", abort_o, m_killed);
    chk("R7", "timeout", timeout_o, m_tmo);
    s_abort = abort_o; s_tmo = timeout_o; s_wait = core_wait_o; s_stb = bus_stb_o;
    ex = exp_expire(c, s, a);
    @(posedge clk);
    if (r) begin
      m_cnt = 0; m_killed = 1'b0; m_tmo = 1'b0;
    end else begin
      m_tmo    = ex;
      m_killed = m_killed ? (c && s) : ex;
      m_cnt    = (!lv || a) ? 0 : m_cnt + 1;
    end
  endtask

  task automatic drop_and_idle();
    step(1'b0, 1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    void'($urandom(32'h5eed_0417));
    // R9: reset state
    step(1'b1, 1'b1, 1'b1, 1'b0);
    step(1'b1, 1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b0, 1'b0);
    chk("R9", "abort after reset", s_abort, 1'b0);
    chk("R9", "timeout after reset", s_tmo, 1'b0);

    // R3, R7, R6: full timeout
    for (int i = 0; i < LIMIT; i++) step(1'b0, 1'b1, 1'b1, 1'b0);
    chk("R3", "abort before window end", s_abort, 1'b0);
    step(1'b0, 1'b1, 1'b1, 1'b0);
    chk("R3", "abort after window", s_abort, 1'b1);
    chk("R7", "pulse on first abort cycle", s_tmo, 1'b1);
    chk("R5", "stb killed", s_stb, 1'b0);
    step(1'b0, 1'b1, 1'b1, 1'b1);
    chk("R6", "abort held", s_abort, 1'b1);
    chk("R7", "pulse ends", s_tmo, 1'b0);
    step(1'b0, 1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b0, 1'b0);
    chk("R6", "abort released", s_abort, 1'b0);

    // R8: acknowledge in the last cycle wins
    for (int i = 0; i < LIMIT - 1; i++) step(1'b0, 1'b1, 1'b1, 1'b0);
    step(1'b0, 1'b1, 1'b1, 1'b1);
    step(1'b0, 1'b0, 1'b0, 1'b0);
    chk("R8", "no abort on late ack", s_abort, 1'b0);
    chk("R8", "no pulse on late ack", s_tmo, 1'b0);

    // R4: back-to-back transfer gets a fresh window
    for (int i = 0; i < 10; i++) step(1'b0, 1'b1, 1'b1, 1'b0);
    step(1'b0, 1'b1, 1'b1, 1'b1);
    for (int i = 0; i < LIMIT; i++) step(1'b0, 1'b1, 1'b1, 1'b0);
    chk("R4", "no abort inside fresh window", s_abort, 1'b0);
    step(1'b0, 1'b1, 1'b1, 1'b0);
    chk("R4", "abort at end of fresh window", s_abort, 1'b1);

    // R9: reset in the middle of an abort
    step(1'b1, 1'b1, 1'b1, 1'b0);
    step(1'b0, 1'b1, 1'b1, 1'b0);
    chk("R9", "abort cleared by reset", s_abort, 1'b0);
    chk("R9", "wait restored after reset", s_wait, 1'b1);
    drop_and_idle();

    // random traffic
    for (int t = 0; t < 300; t++) begin
      int gap;
      gap = int'($urandom % 4);
      for (int g = 0; g < gap; g++)
        step(1'b0, 1'($urandom % 2), 1'b0, 1'($urandom % 2));
      if ($urandom % 24 == 0) begin
        int extra;
        for (int i = 0; i < LIMIT; i++) step(1'b0, 1'b1, 1'b1, 1'b0);
        extra = 1 + int'($urandom % 3);
        for (int i = 0; i < extra; i++) step(1'b0, 1'b1, 1'b1, 1'($urandom % 2));
        drop_and_idle();
      end else begin
        int d;
        d = int'($urandom % 20);
        for (int i = 0; i < d; i++) step(1'b0, 1'b1, 1'b1, 1'b0);
        step(1'b0, 1'b1, 1'b1, 1'b1);
      end
    end
    drop_and_idle();

    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

endmodule